// File: doc/BRIEF.md
# Frame Viterbi Decoder (rate 1/2, K=3, hard decision)

This block recovers 8 information bits from a 16-bit received frame produced by a rate 1/2, constraint length 3 convolutional encoder. The generator polynomials are 7 and 5 (octal). Symbols arrive one pair per cycle whenever `symValid` is high. For each accepted pair the block computes Hamming branch metrics against the four trellis states. Add-compare-select updates the path metrics, and one decision bit per state goes into an 8-deep survivor store.

After the eighth pair the block raises `busy` and ignores further input. It picks the state with the lowest path metric and walks the survivor store backwards, one step per cycle. It then presents the decoded word with a one-cycle `outValid` pulse. Path metrics then return to their start values: state 0 at zero, all other states at the saturated maximum. The next frame begins from a fresh trellis.

Top module: `vit_frame_decoder`

## Requirements
- R1: After reset, `busy` and `outValid` are 0.
- R2: The encoder model has these properties. Its shift register starts at zero. Each information bit u, with previous bits p1 (newer) and p2 (older), yields the pair `symIn[1]` = u^p1^p2 and `symIn[0]` = u^p2. The decoded word places the first transmitted bit in `outData[7]`. Every one of the 256 error-free frames decodes to its own information word.
- R3: With one flipped channel bit, if exactly one information word encodes to a codeword at minimum Hamming distance from the received frame, `outData` equals that word.
- R4: With two flipped, non-adjacent channel bits, the same unique-nearest rule as in R3 holds.
- R5: `busy` rises on the cycle after the eighth pair is accepted. While `busy` is high, `symIn`/`symValid` have no effect, so the following frame still decodes correctly.
- R6: `outValid` lasts exactly one cycle, with `busy` high during it and low in the following cycle.
- R7: `outValid` is high in the cycle that follows the 8th rising clock edge after the edge that accepts the last pair.
- R8: Frames sent back to back, and frames sent with idle gaps between pairs, decode independently of earlier frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| symValid | input | 1 | Received pair valid strobe |
| symIn | input | 2 | Received pair: [1] generator-7 bit, [0] generator-5 bit |
| busy | output | 1 | Traceback in progress, input ignored |
| outValid | output | 1 | One-cycle pulse with decoded word |
| outData | output | 8 | Decoded word, first bit in MSB |

## Verification
A wrong path metric or a wrong decision bit shows up only when a frame finishes. It does not always show: it appears as a wrong `outData` bit on frames where the corrupted state lies on the surviving path, usually on error-bearing frames. The sweeps therefore cover every error-free word and every single-bit error, and they compare against a brute-force nearest-codeword search. Stale metrics left over from a previous frame corrupt the next decoded word. A sequencing error in the control shifts `outValid` off its fixed cycle, or leaves `busy` set around it.

// File: rtl/vit_pkg.sv
package vit_pkg;
  localparam int NSTATE = 4;
  localparam int SW     = 2;

  typedef struct packed {
    logic accept;
    logic traceStep;
    logic traceFirst;
    logic clearMetrics;
    logic emit;
  } vit_ctrl_t;
endpackage

// File: rtl/vit_control.sv
module vit_control
  import vit_pkg::*;
#(
  parameter int FRAME_LEN = 8,
  localparam int IDX_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             symValid,
  output vit_ctrl_t        ctrl,
  output logic [IDX_W-1:0] idx,
  output logic             busy
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

  typedef enum logic [1:0] {COLLECT, TRACE, EMIT} phase_t;
  phase_t phase;

  always_comb begin
    ctrl = '0;
    ctrl.accept       = (phase == COLLECT) && symValid;
    ctrl.traceStep    = (phase == TRACE);
    ctrl.traceFirst   = (phase == TRACE) && (idx == LAST);
    ctrl.emit         = (phase == EMIT);
    ctrl.clearMetrics = (phase == EMIT);
  end

  assign busy = (phase != COLLECT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= COLLECT;
      idx   <= '0;
    end else begin
      unique case (phase)
        COLLECT: if (symValid) begin
          if (idx == LAST) phase <= TRACE;
          else             idx   <= idx + 1'b1;
        end
        TRACE: begin
          if (idx == '0) phase <= EMIT;
          else           idx   <= idx - 1'b1;
        end
        EMIT: begin
          phase <= COLLECT;
          idx   <= '0;
        end
        default: phase <= COLLECT;
      endcase
    end
  end
endmodule

// File: rtl/vit_datapath.sv
module vit_datapath
  import vit_pkg::*;
#(
  parameter int FRAME_LEN = 8,
  parameter int PM_W      = 5,
  localparam int IDX_W = $clog2(FRAME_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  vit_ctrl_t            ctrl,
  input  logic [IDX_W-1:0]     idx,
  input  logic [SW-1:0]        symIn,
  output logic [FRAME_LEN-1:0] decodedWord
);
  localparam logic [PM_W-1:0] PM_MAX = '1;

  logic [PM_W-1:0]   pathMetric [NSTATE];
  logic [PM_W-1:0]   nextMetric [NSTATE];
  logic [NSTATE-1:0] decisions;
  logic [NSTATE-1:0] survivor   [FRAME_LEN];
  logic [1:0]        bestState, traceState, curState;

  function automatic logic [PM_W-1:0] satAdd(input logic [PM_W-1:0] a,
                                             input logic [1:0] b);
    logic [PM_W:0] s;
    s = {1'b0, a} + {{(PM_W-1){1'b0}}, b};
    return s[PM_W] ? PM_MAX : s[PM_W-1:0];
  endfunction

  for (genvar ns = 0; ns < NSTATE; ns++) begin : g_acs
    localparam int U  = (ns >> 1) & 1;
    localparam int A  = ns & 1;
    localparam int P0 = A * 2;
    localparam int P1 = A * 2 + 1;
    localparam logic [1:0] EXP0 = {1'(U ^ A), 1'(U)};
    localparam logic [1:0] EXP1 = {1'(U ^ A ^ 1), 1'(U ^ 1)};
    logic [1:0] diff0, diff1, bm0, bm1;
    logic [PM_W-1:0] cand0, cand1;
    always_comb begin
      diff0 = symIn ^ EXP0;
      diff1 = symIn ^ EXP1;
      bm0   = {1'b0, diff0[1]} + {1'b0, diff0[0]};
      bm1   = {1'b0, diff1[1]} + {1'b0, diff1[0]};
      cand0 = satAdd(pathMetric[P0], bm0);
      cand1 = satAdd(pathMetric[P1], bm1);
      decisions[ns]  = (cand1 < cand0);
      nextMetric[ns] = (cand1 < cand0) ? cand1 : cand0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n || ctrl.clearMetrics)
        pathMetric[ns] <= (ns == 0) ? '0 : PM_MAX;
      else if (ctrl.accept)
        pathMetric[ns] <= nextMetric[ns];
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.accept) survivor[idx] <= decisions;
  end

  always_comb begin
    logic [PM_W-1:0] bestPm;
    bestState = 2'd0;
    bestPm    = pathMetric[0];
    for (int s = 1; s < NSTATE; s++) begin
      if (pathMetric[s] < bestPm) begin
        bestPm    = pathMetric[s];
        bestState = 2'(s);
      end
    end
  end

  assign curState = ctrl.traceFirst ? bestState : traceState;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      traceState  <= '0;
      decodedWord <= '0;
    end else if (ctrl.traceStep) begin
      decodedWord[IDX_W'(FRAME_LEN - 1) - idx] <= curState[1];
      traceState <= {curState[0], survivor[idx][curState]};
    end
  end
endmodule

// File: rtl/vit_frame_decoder.sv
module vit_frame_decoder
  import vit_pkg::*;
#(
  parameter int FRAME_LEN = 8,
  parameter int PM_W      = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 symValid,
  input  logic [1:0]           symIn,
  output logic                 busy,
  output logic                 outValid,
  output logic [FRAME_LEN-1:0] outData
);
  localparam int IDX_W = $clog2(FRAME_LEN);

  vit_ctrl_t        ctrl;
  logic [IDX_W-1:0] idx;

  vit_control #(.FRAME_LEN(FRAME_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .symValid(symValid),
    .ctrl(ctrl), .idx(idx), .busy(busy)
  );

  vit_datapath #(.FRAME_LEN(FRAME_LEN), .PM_W(PM_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .idx(idx),
    .symIn(symIn), .decodedWord(outData)
  );

  assign outValid = ctrl.emit;
endmodule

// File: rtl/vit_frame_decoder_checker.sv
module vit_frame_decoder_checker (
  input logic clk,
  input logic rst_n,
  input logic symValid,
  input logic busy,
  input logic outValid
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |=> !outValid);                                   // R6
  AST_BUSY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> busy);                                        // R6
  AST_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |=> !busy);                                       // R6
  AST_FALL_ONLY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(outValid));                          // R5
  AST_RISE_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(symValid));                          // R5
  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !outValid);                                      // R1
endmodule

bind vit_frame_decoder vit_frame_decoder_checker u_chk (
  .clk(clk), .rst_n(rst_n), .symValid(symValid),
  .busy(busy), .outValid(outValid)
);

// File: tb/vit_frame_decoder_test.sv
module vit_frame_decoder_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       symValid = 0;
  logic [1:0] symIn = '0;
  logic       busy, outValid;
  logic [7:0] outData;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  vit_frame_decoder uut (
    .clk(clk), .rst_n(rst_n), .symValid(symValid), .symIn(symIn),
    .busy(busy), .outValid(outValid), .outData(outData)
  );

  function automatic logic [15:0] encode(input logic [7:0] w);
    logic p1, p2, u;
    logic [15:0] f;
    p1 = 0; p2 = 0; f = '0;
    for (int i = 0; i < 8; i++) begin
      u = w[7-i];
      f[15-2*i] = u ^ p1 ^ p2;
      f[14-2*i] = u ^ p2;
      p2 = p1; p1 = u;
    end
    return f;
  endfunction

  function automatic void nearest(input logic [15:0] rx, output logic [7:0] best,
                                  output logic unique1);
    int bd, cnt;
    bd = 99; cnt = 0; best = '0;
    for (int w = 0; w < 256; w++) begin
      int d;
      d = $countones(encode(8'(w)) ^ rx);
      if (d < bd) begin bd = d; cnt = 1; best = 8'(w); end
      else if (d == bd) cnt++;
    end
    unique1 = (cnt == 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // gap: idle cycle after each pair; junk: drive symbols while busy
  task automatic runFrame(input logic [15:0] rx, input logic gap, input logic junk,
                          input logic [7:0] expWord, input string req, input logic timing);
    int lat;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      symValid = 1; symIn = rx[15-2*i -: 2];
      if (gap && i < 7) begin @(negedge clk); symValid = 0; end
    end
    @(negedge clk);
    symValid = junk; symIn = junk ? 2'b11 : 2'b00;
    lat = 0;
    while (!outValid && lat < 100) begin
      @(negedge clk); lat++;
      if (junk) symIn = 2'(lat);
    end
    symValid = 0;
    if (lat >= 100) begin
      checks++; fails++;
      $display("FAIL watchdog %s no outValid actual=%0d expected=8", req, lat);
      return;
    end
    check(req, outData, expWord);
    if (timing) begin
      check("R7 latency", lat, 8);
      check("R6 busy during pulse", busy, 1);
      @(negedge clk);
      check("R6 pulse one cycle", outValid, 0);
      check("R6 busy released", busy, 0);
    end else begin
      @(negedge clk);
    end
  endtask

  initial begin
    logic [7:0] nw;
    logic       un;
    repeat (3) @(negedge clk);
    check("R1 busy at reset", busy, 0);
    check("R1 outValid at reset", outValid, 0);
    rst_n = 1;

    // R2 and R8: every error-free word, alternating gapped/back-to-back
    for (int w = 0; w < 256; w++)
      runFrame(encode(8'(w)), w[0], 1'b0, 8'(w), "R2 error-free", w < 4);

    // R5: junk while busy, then a clean frame must still decode
    runFrame(encode(8'hA5), 1'b0, 1'b1, 8'hA5, "R5 frame before junk", 1'b1);
    runFrame(encode(8'h3C), 1'b0, 1'b0, 8'h3C, "R5 after junk", 1'b1);

    // R3: every single-bit error over every word
    for (int w = 0; w < 256; w++)
      for (int p = 0; p < 16; p++) begin
        logic [15:0] rx;
        rx = encode(8'(w)) ^ (16'h1 << p);
        nearest(rx, nw, un);
        if (un) runFrame(rx, 1'b0, 1'b0, nw, "R3 single error", 1'b0);
      end

    // R4: non-adjacent double errors over a spread of words
    for (int k = 0; k < 16; k++)
      for (int p = 0; p < 16; p++)
        for (int q = p + 2; q < 16; q++) begin
          logic [15:0] rx;
          rx = encode(8'(k * 17)) ^ (16'h1 << p) ^ (16'h1 << q);
          nearest(rx, nw, un);
          if (un) runFrame(rx, k[0], 1'b0, nw, "R4 double error", 1'b0);
        end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog global timeout actual=expired expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule